// File: doc/BRIEF.md
# Bitstream Supply-Fault Detector

This block sits at the receiving end of an isolated one-bit delta-sigma link. It samples the data line on each rising edge of the link clock, after both lines have crossed into the local system-clock domain. From the sampled stream it decides whether the far side has lost its supply or is only being driven hard at full scale. A healthy modulator at full scale still produces one bit of the opposite value in every 128. A dead transmitter holds the data line at a fixed idle level instead. That level is 0 when the link clock comes from the receiving side and 1 when the transmitter generates the clock.

When the transmitter generates the clock, its clock line also freezes after a supply loss. The block therefore also watches for missing clock edges in that mode. A fault clears only after a long run of healthy samples. This stops the flag from dropping while the far side is still restarting. Saturation is reported per aligned window as a positive or a negative flag, and both flags are suppressed while a fault is active.

Top module: `lfm_top`

## Requirements
- R1: After reset, `fault`, `sat_pos`, `sat_neg` and `clk_lost` are all 0.
- R2: The idle level is 0 when `int_clk_mode`=0 and 1 when `int_clk_mode`=1. `fault` rises when more than RUN_LIMIT (128) consecutive samples equal the idle level. A run of exactly 128 idle samples followed by a non-idle sample leaves `fault` at 0.
- R3: A run of the non-idle level never raises `fault`, whatever its length (for example 300 ones with `int_clk_mode`=0).
- R4: With `int_clk_mode`=1, if no rising link-clock edge arrives for CLK_TIMEOUT (64) system cycles, `clk_lost` and `fault` both rise. With `int_clk_mode`=0, `clk_lost` stays 0 however long the clock stalls.
- R5: Samples are grouped into aligned windows of WINDOW (128) samples. The first window begins with the first sample after reset. At the end of each window, `sat_pos` becomes 1 if that window held exactly one 0. `sat_neg` becomes 1 if the window held exactly one 1. Otherwise both become 0. Each value holds until the next window ends.
- R6: While `fault` is 1, `sat_pos` and `sat_neg` read 0.
- R7: Once set, `fault` clears only after RECOVER (256) consecutive samples taken with no idle-run or clock-loss condition active. Any new fault condition restarts this count.
- R8: Data is taken only at rising link-clock edges, after a two-flop synchroniser. Data pulses that occur between rising edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_dat | input | 1 | Modulator bit from the isolated link |
| link_clk | input | 1 | Bit clock from the isolated link |
| int_clk_mode | input | 1 | 1: transmitter generates the clock (idle level 1); 0: clock supplied locally (idle level 0) |
| fault | output | 1 | Far-side supply loss detected |
| sat_pos | output | 1 | Last window was positive full scale |
| sat_neg | output | 1 | Last window was negative full scale |
| clk_lost | output | 1 | Link clock missing (internal-clock mode only) |

## Verification
An idle-run counter that is off by one shows as `fault` rising one sample too early or too late at the 128/129 boundary. This appears within a single link-clock period of the deciding sample. A recovery counter that does not restart, or restarts too often, moves the falling edge of `fault` away from sample 257 after the stream becomes healthy again. A slipped window counter flips `sat_pos`/`sat_neg` at the first window boundary after the slip. A bad clock-loss timer is visible as `clk_lost` missing, or appearing in the wrong mode, a few dozen system cycles into a stall.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } clk_src_e;

   // Level a dead transmitter leaves on the data line for a given clock source.
   function automatic logic idle_level(input clk_src_e src);
      return (src == SRC_INTERNAL);
   endfunction
endpackage

// File: rtl/lfm_sync.sv
module lfm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dat_in,
   input  logic lclk_in,
   output logic smp,
   output logic smp_bit
);
   logic [STAGES-1:0] dat_q;
   logic [STAGES-1:0] lclk_q;
   logic              lclk_last;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  dat_q[0]  <= 1'b0;
                  lclk_q[0] <= 1'b0;
               end else begin
                  dat_q[0]  <= dat_in;
                  lclk_q[0] <= lclk_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  dat_q[g]  <= 1'b0;
                  lclk_q[g] <= 1'b0;
               end else begin
                  dat_q[g]  <= dat_q[g-1];
                  lclk_q[g] <= lclk_q[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lclk_last <= 1'b0;
      else        lclk_last <= lclk_q[STAGES-1];
   end

   assign smp     = lclk_q[STAGES-1] & ~lclk_last;
   assign smp_bit = dat_q[STAGES-1];
endmodule

// File: rtl/lfm_run_mon.sv
module lfm_run_mon #(
   parameter int RUN_LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic smp_bit,
   input  logic idle,
   output logic run_hit
);
   localparam int RW = $clog2(RUN_LIMIT + 2);
   localparam logic [RW-1:0] LIM = RW'(RUN_LIMIT);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (smp) begin
         if (smp_bit != idle)  run_q <= '0;
         else if (run_q <= LIM) run_q <= run_q + 1'b1;
      end
   end

   assign run_hit = (run_q > LIM);
endmodule

// File: rtl/lfm_clk_watch.sv
module lfm_clk_watch #(
   parameter int TIMEOUT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_seen,
   input  logic enable,
   output logic lost
);
   localparam int CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] TO = CW'(TIMEOUT);

   logic [CW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gap_q <= '0;
      else if (edge_seen)   gap_q <= '0;
      else if (gap_q != TO) gap_q <= gap_q + 1'b1;
   end

   assign lost = enable && (gap_q == TO);
endmodule

// File: rtl/lfm_sat_det.sv
module lfm_sat_det #(
   parameter int WINDOW = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic smp_bit,
   output logic pos,
   output logic neg
);
   localparam int WW = $clog2(WINDOW);
   localparam int OW = $clog2(WINDOW + 1);
   localparam logic [WW-1:0] LAST = WW'(WINDOW - 1);

   logic [WW-1:0] pos_in_win;
   logic [OW-1:0] ones_q;
   logic [OW-1:0] ones_tot;

   assign ones_tot = ones_q + OW'(smp_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_in_win <= '0;
         ones_q     <= '0;
         pos        <= 1'b0;
         neg        <= 1'b0;
      end else if (smp) begin
         if (pos_in_win == LAST) begin
            pos        <= (ones_tot == OW'(WINDOW - 1));
            neg        <= (ones_tot == OW'(1));
            pos_in_win <= '0;
            ones_q     <= '0;
         end else begin
            pos_in_win <= pos_in_win + 1'b1;
            ones_q     <= ones_tot;
         end
      end
   end
endmodule

// File: rtl/lfm_fault_ctl.sv
module lfm_fault_ctl #(
   parameter int RECOVER = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic run_hit,
   input  logic clk_lost,
   output logic fault
);
   localparam int RCW = $clog2(RECOVER);
   localparam logic [RCW-1:0] RC_LAST = RCW'(RECOVER - 1);

   logic [RCW-1:0] heal_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault  <= 1'b0;
         heal_q <= '0;
      end else if (run_hit || clk_lost) begin
         fault  <= 1'b1;
         heal_q <= '0;
      end else if (fault && smp) begin
         if (heal_q == RC_LAST) begin
            fault  <= 1'b0;
            heal_q <= '0;
         end else begin
            heal_q <= heal_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lfm_top.sv
module lfm_top #(
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LIMIT   = 128,
   parameter int WINDOW      = 128,
   parameter int RECOVER     = 256,
   parameter int CLK_TIMEOUT = 64,
   parameter bit SAT_ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_dat,
   input  logic link_clk,
   input  logic int_clk_mode,
   output logic fault,
   output logic sat_pos,
   output logic sat_neg,
   output logic clk_lost
);
   import lfm_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RUN_LIMIT < 2) begin : g_bad_run
         $error("RUN_LIMIT must be at least 2");
      end
      if (WINDOW < 4) begin : g_bad_win
         $error("WINDOW must be at least 4");
      end
      if (RECOVER < 2) begin : g_bad_rec
         $error("RECOVER must be at least 2");
      end
      if (CLK_TIMEOUT < 4) begin : g_bad_to
         $error("CLK_TIMEOUT must be at least 4");
      end
   endgenerate

   clk_src_e src;
   logic     idle;
   logic     smp;
   logic     smp_bit;
   logic     run_hit;
   logic     sat_pos_q;
   logic     sat_neg_q;

   assign src  = clk_src_e'(int_clk_mode);
   assign idle = idle_level(src);

   lfm_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .dat_in(link_dat), .lclk_in(link_clk),
      .smp(smp), .smp_bit(smp_bit)
   );

   lfm_run_mon #(.RUN_LIMIT(RUN_LIMIT)) run_i (
      .clk(clk), .rst_n(rst_n), .smp(smp), .smp_bit(smp_bit), .idle(idle),
      .run_hit(run_hit)
   );

   lfm_clk_watch #(.TIMEOUT(CLK_TIMEOUT)) watch_i (
      .clk(clk), .rst_n(rst_n), .edge_seen(smp),
      .enable(src == SRC_INTERNAL), .lost(clk_lost)
   );

   generate
      if (SAT_ENABLE) begin : g_sat
         lfm_sat_det #(.WINDOW(WINDOW)) sat_i (
            .clk(clk), .rst_n(rst_n), .smp(smp), .smp_bit(smp_bit),
            .pos(sat_pos_q), .neg(sat_neg_q)
         );
      end else begin : g_no_sat
         assign sat_pos_q = 1'b0;
         assign sat_neg_q = 1'b0;
      end
   endgenerate

   lfm_fault_ctl #(.RECOVER(RECOVER)) ctl_i (
      .clk(clk), .rst_n(rst_n), .smp(smp), .run_hit(run_hit),
      .clk_lost(clk_lost), .fault(fault)
   );

   assign sat_pos = sat_pos_q & ~fault;
   assign sat_neg = sat_neg_q & ~fault;
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
   input logic clk,
   input logic rst_n,
   input logic int_clk_mode,
   input logic smp,
   input logic run_hit,
   input logic clk_lost,
   input logic fault,
   input logic sat_pos,
   input logic sat_neg
);
   assert_run_sets_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_hit |=> fault);

   assert_lost_only_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |-> int_clk_mode);

   assert_lost_sets_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |=> fault);

   assert_sat_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sat_pos && sat_neg));

   assert_sat_quiet_in_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(sat_pos || sat_neg));

   assert_clear_on_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault) |-> $past(smp) && !$past(run_hit) && !$past(clk_lost));
endmodule

bind lfm_top lfm_checker chk_i (
   .clk(clk), .rst_n(rst_n), .int_clk_mode(int_clk_mode), .smp(smp),
   .run_hit(run_hit), .clk_lost(clk_lost), .fault(fault),
   .sat_pos(sat_pos), .sat_neg(sat_neg)
);

// File: tb/lfm_top_tb_top.sv
`timescale 1ns/1ps
module lfm_top_tb_top;
   localparam int RUN_LIMIT = 128;
   localparam int WIN       = 128;
   localparam int RECOVER   = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_dat = 1'b0;
   logic link_clk = 1'b0;
   logic int_clk_mode = 1'b0;
   logic fault, sat_pos, sat_neg, clk_lost;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Bench model state
   int m_run, m_rec, m_w, m_ones;
   bit m_fault, m_sp, m_sn, m_lost, m_idle;

   always #5 clk = ~clk;

   lfm_top dut_i (
      .clk(clk), .rst_n(rst_n), .link_dat(link_dat), .link_clk(link_clk),
      .int_clk_mode(int_clk_mode), .fault(fault), .sat_pos(sat_pos),
      .sat_neg(sat_neg), .clk_lost(clk_lost)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_pos();
      return m_sp && !m_fault;
   endfunction

   function automatic bit exp_neg();
      return m_sn && !m_fault;
   endfunction

   task automatic cmp_all(input string tag);
      chk({tag, " fault"}, int'(fault), int'(m_fault));
      chk({tag, " sat_pos"}, int'(sat_pos), int'(exp_pos()));
      chk({tag, " sat_neg"}, int'(sat_neg), int'(exp_neg()));
      chk({tag, " clk_lost"}, int'(clk_lost), int'(m_lost));
   endtask

   task automatic model_step(input bit b);
      bit old_hit;
      old_hit = (m_run > RUN_LIMIT) || m_lost;
      if (old_hit) m_rec = 0;
      else if (m_fault) begin
         m_rec++;
         if (m_rec == RECOVER) begin
            m_fault = 1'b0;
            m_rec = 0;
         end
      end
      m_lost = 1'b0;
      if (b == m_idle) begin
         if (m_run <= RUN_LIMIT) m_run++;
      end else m_run = 0;
      if (m_run > RUN_LIMIT) begin
         m_fault = 1'b1;
         m_rec = 0;
      end
      m_ones += int'(b);
      if (m_w == WIN - 1) begin
         m_sp = (m_ones == WIN - 1);
         m_sn = (m_ones == 1);
         m_w = 0;
         m_ones = 0;
      end else m_w++;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0;
      int_clk_mode = mode;
      link_clk = 1'b0;
      link_dat = 1'b0;
      m_run = 0; m_rec = 0; m_w = 0; m_ones = 0;
      m_fault = 0; m_sp = 0; m_sn = 0; m_lost = 0; m_idle = mode;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      cmp_all("R1 reset");
   endtask

   // One link bit: low phase with data set (optional opposite pulse), then rising edge.
   task automatic send_bit(input bit b, input bit glitch);
      link_dat = b;
      link_clk = 1'b0;
      @(negedge clk);
      if (glitch) begin
         link_dat = ~b;
         @(negedge clk);
         link_dat = b;
      end else @(negedge clk);
      repeat (2) @(negedge clk);
      link_clk = 1'b1;
      repeat (4) @(negedge clk);
      link_clk = 1'b0;
      repeat (2) @(negedge clk);
      model_step(b);
      cmp_all("R2/R5/R7/R8 per-sample");
   endtask

   task automatic stall();
      link_clk = 1'b1;
      repeat (80) @(negedge clk);
      model_step(link_dat);
      if (int_clk_mode) begin
         m_lost = 1'b1;
         m_fault = 1'b1;
         m_rec = 0;
      end
      cmp_all("R4 stall");
   endtask

   task automatic send_sat_windows(input bit pol, input int pos, input int nwin);
      for (int w = 0; w < nwin; w++)
         for (int i = 0; i < WIN; i++)
            send_bit((i == pos) ? ~pol : pol, 1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R2 boundary, external mode (idle 0)
      do_reset(1'b0);
      for (int i = 0; i < 128; i++) send_bit(1'b0, 1'b0);
      chk("R2 128 idle no fault", int'(fault), 0);
      send_bit(1'b1, 1'b0);
      chk("R2 run broken no fault", int'(fault), 0);
      for (int i = 0; i < 129; i++) send_bit(1'b0, 1'b0);
      chk("R2 129 idle fault", int'(fault), 1);

      // R7 recovery timing
      for (int i = 0; i < 200; i++) send_bit(i[0], 1'b0);
      chk("R7 still held after 200", int'(fault), 1);
      for (int i = 0; i < 100; i++) send_bit(i[0], 1'b0);
      chk("R7 cleared after 300", int'(fault), 0);

      // R3 long non-idle run
      do_reset(1'b0);
      for (int i = 0; i < 300; i++) send_bit(1'b1, 1'b0);
      chk("R3 long ones no fault", int'(fault), 0);

      // R8 pulses between edges ignored
      do_reset(1'b0);
      for (int i = 0; i < 140; i++) send_bit(1'b0, 1'b1);
      chk("R8 glitches ignored", int'(fault), 1);

      // R5 saturation positive then negative
      do_reset(1'b0);
      send_sat_windows(1'b1, 10, 2);
      chk("R5 sat_pos", int'(sat_pos), 1);
      chk("R5 sat_neg low", int'(sat_neg), 0);
      send_sat_windows(1'b0, 77, 1);
      chk("R5 sat_neg", int'(sat_neg), 1);
      chk("R5 sat_pos low", int'(sat_pos), 0);
      for (int i = 0; i < WIN; i++) send_bit((i % 50) == 3, 1'b0);
      chk("R5 three ones neither", int'(sat_neg) + int'(sat_pos), 0);

      // R4 / R6 internal mode clock loss while saturated
      do_reset(1'b1);
      send_sat_windows(1'b1, 60, 2);
      chk("R6 sat_pos before loss", int'(sat_pos), 1);
      stall();
      chk("R4 clk_lost internal", int'(clk_lost), 1);
      chk("R4 fault on loss", int'(fault), 1);
      chk("R6 sat_pos masked", int'(sat_pos), 0);
      for (int i = 0; i < 300; i++) send_bit(i[0], 1'b0);
      chk("R7 recovered after clock return", int'(fault), 0);

      // R4 external mode stall
      do_reset(1'b0);
      for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
      stall();
      chk("R4 no clk_lost external", int'(clk_lost), 0);
      chk("R4 no fault external stall", int'(fault), 0);

      // Constrained random segments in both modes
      void'($urandom(32'h5eed_1234));
      for (int mode = 0; mode < 2; mode++) begin
         do_reset(mode[0]);
         for (int seg = 0; seg < 14; seg++) begin
            int kind;
            kind = int'($urandom % 5);
            case (kind)
               0: for (int i = 0; i < 64; i++) send_bit(bit'($urandom % 2), 1'b0);
               1: begin
                  int len;
                  len = 100 + int'($urandom % 60);
                  for (int i = 0; i < len; i++) send_bit(m_idle, 1'b0);
               end
               2: for (int i = 0; i < 150; i++) send_bit(~m_idle, bit'($urandom % 2));
               3: begin
                  int p;
                  bit pol;
                  while (m_w != 0) send_bit(bit'($urandom % 2), 1'b0);
                  p = int'($urandom % WIN);
                  pol = bit'($urandom % 2);
                  send_sat_windows(pol, p, 2);
               end
               default: if (mode == 1) stall();
                        else for (int i = 0; i < 20; i++) send_bit(bit'($urandom % 2), 1'b1);
            endcase
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule